// File: doc/BRIEF.md
# Out-of-band flow control transmitter

This block sends per-channel XON/XOFF calendar bits to a link partner over three wires: a forwarded clock, a serial data line and a sync line. A calendar bit of 1 means XON and a bit of 0 means XOFF. When enabled, an interface health bit and a set of lane health bits go in front of the calendar. The user side runs on a system clock. The block asks for fresh calendar data one 64-bit slice at a time with a one-hot update strobe, and it samples the slice in the cycle the strobe is high.

The serial side runs from a reference clock of at most 200 MHz. It forwards a clock at half that rate and sends frames back to back. Every 64 payload bits, and after the last partial group, it appends a 4-bit CRC. Each latched slice crosses into the reference domain through a toggle handshake. A sticky rate-error flag rises when a frame has to start before every active slice has been refreshed since the previous frame started.

Top module: `oobfc_tx`

## Requirements
- R1: `fc_clk_o` toggles on every reference clock edge once reset has been released, so it runs at half the reference rate.
- R2: `fc_data_o` and `fc_sync_o` change only when `fc_clk_o` falls, so the partner can sample them on the rising edge.
- R3: A frame carries bit 0 as the interface bit and then lane bits 0 upward when status is on, followed by calendar bits 0 to `cal_len_m1`. Each bit is sent as driven, with 1 meaning XON.
- R4: A 4-bit CRC with polynomial x^4+x+1 and seed 4'b1111 follows every 64 payload bits and also the final partial group. It is sent MSB first, and an exact multiple of 64 adds no empty group.
- R5: `fc_sync_o` is high only during the first bit of each frame, and the next frame starts right after the last CRC bit.
- R6: With `status_en` at 0, no status bits are sent, and the values of `intf_ok` and `lane_ok` have no effect on the frame.
- R7: With status on, exactly `lane_cnt_m1`+1 lane bits are sent.
- R8: `upd_stb` is one-hot or zero and never high in two consecutive cycles. It cycles over slices 0 to `cal_len_m1`/64 only. Strobe bit k latches `fc_vec[64k+63:64k]` at the end of its cycle. Strobe bit 0 also latches `intf_ok` and `lane_ok`.
- R9: After reset, all outputs are 0. No frame is sent until every active slice has been latched once.
- R10: `rate_err` rises when a frame starts with fewer slices taken since the previous frame start than there are active slices. It stays high until reset and stays low while the user clock keeps up.
- R11: `rst` is asynchronous. Raising it clears the outputs at once, and it is synchronised into each clock domain for release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock |
| ref_clk | input | 1 | Serial reference clock, at most 200 MHz |
| rst | input | 1 | Asynchronous active-high reset |
| fc_vec | input | MAX_CALLEN | Calendar bits, 1 = XON |
| cal_len_m1 | input | 8 | Calendar length minus one |
| lane_cnt_m1 | input | $clog2(LANES) | Number of lane bits minus one |
| intf_ok | input | 1 | Interface health to send |
| lane_ok | input | LANES | Per-lane health to send |
| status_en | input | 1 | Include the status bits in the frame |
| upd_stb | output | ceil(MAX_CALLEN/64) | One-hot slice latch strobe |
| rate_err | output | 1 | Sticky rate-error flag, user clock domain |
| fc_clk_o | output | 1 | Forwarded link clock |
| fc_data_o | output | 1 | Serial frame data |
| fc_sync_o | output | 1 | Frame start marker |

## Verification
The properties assume that `cal_len_m1`, `lane_cnt_m1` and `status_en` are static whenever `rst` is low. They also assume that calendar bits above the configured length are driven to zero and that the user clock keeps up with the reference clock, except where a rate fault is provoked on purpose. The stimulus changes configuration only while reset is held and masks the calendar vector to the programmed length. It stops the user clock only in the single test that is meant to raise `rate_err`, and that test ends with a reset.

// File: rtl/oobfc_pkg.sv
`timescale 1ns/1ps
package oobfc_pkg;
  localparam int SLICE_W = 64;

  typedef enum logic [0:0] {ST_PAY, ST_CRC} ser_st_e;

  // one serial step of x^4+x+1
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2], c[1], c[0] ^ fb, fb};
  endfunction

  function automatic logic [8:0] active_slices(input logic [7:0] len_m1);
    return 9'(len_m1 >> 6) + 9'd1;
  endfunction

  function automatic logic [9:0] payload_bits(input logic [7:0] len_m1,
                                               input logic [7:0] lanes_m1,
                                               input logic sen);
    return 10'(len_m1) + 10'd1 + (sen ? (10'(lanes_m1) + 10'd2) : 10'd0);
  endfunction
endpackage

// File: rtl/oobfc_rst_sync.sv
`timescale 1ns/1ps
module oobfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_a,
  output logic rst_s
);
  logic [STAGES-1:0] pipe;
  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], 1'b0};
  end
  assign rst_s = pipe[STAGES-1];
endmodule

// File: rtl/oobfc_bit_sync.sv
`timescale 1ns/1ps
module oobfc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_s,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;
  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) ff <= '0;
    else       ff <= {ff[STAGES-2:0], d};
  end
  assign q = ff[STAGES-1];
endmodule

// File: rtl/oobfc_user_side.sv
`timescale 1ns/1ps
module oobfc_user_side
  import oobfc_pkg::*;
#(
  parameter int MAX_CALLEN  = 128,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NSEG  = (MAX_CALLEN + SLICE_W - 1) / SLICE_W,
  localparam int PAD_W = NSEG * SLICE_W,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_s,
  input  logic [MAX_CALLEN-1:0] fc_vec,
  input  logic [7:0]            cal_len_m1,
  input  logic                  intf_ok,
  input  logic [LANES-1:0]      lane_ok,
  input  logic                  ack_tgl,
  output logic [NSEG-1:0]       upd_stb,
  output logic                  req_tgl,
  output logic [SLICE_W-1:0]    hold_data,
  output logic [IDX_W-1:0]      hold_idx,
  output logic                  hold_intf,
  output logic [LANES-1:0]      hold_lane
);
  logic [PAD_W-1:0] fc_pad;
  logic             ack_s;
  logic [IDX_W-1:0] next_idx;
  logic [8:0]       nact;
  logic             idle_w;

  assign fc_pad = PAD_W'(fc_vec);
  assign nact   = active_slices(cal_len_m1);
  assign idle_w = (ack_s == req_tgl) && (upd_stb == '0);

  oobfc_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_s(rst_s), .d(ack_tgl), .q(ack_s));

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) begin
      upd_stb   <= '0;
      next_idx  <= '0;
      req_tgl   <= 1'b0;
      hold_data <= '0;
      hold_idx  <= '0;
      hold_intf <= 1'b0;
      hold_lane <= '0;
    end else begin
      upd_stb <= '0;
      if (idle_w) upd_stb <= NSEG'(1) << next_idx;
      if (upd_stb != '0) begin
        hold_data <= fc_pad[int'(next_idx)*SLICE_W +: SLICE_W];
        hold_idx  <= next_idx;
        if (next_idx == '0) begin
          hold_intf <= intf_ok;
          hold_lane <= lane_ok;
        end
        req_tgl  <= ~req_tgl;
        next_idx <= (IDX_W'(nact - 9'd1) == next_idx) ? '0 : next_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oobfc_serial_side.sv
`timescale 1ns/1ps
module oobfc_serial_side
  import oobfc_pkg::*;
#(
  parameter int MAX_CALLEN  = 128,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NSEG   = (MAX_CALLEN + SLICE_W - 1) / SLICE_W,
  localparam int PAD_W  = NSEG * SLICE_W,
  localparam int IDX_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int LANE_W = $clog2(LANES),
  localparam int PL_W   = PAD_W + LANES + 1,
  localparam int POS_W  = $clog2(PL_W + 1)
) (
  input  logic               ref_clk,
  input  logic               rst_s,
  input  logic               req_tgl,
  input  logic [SLICE_W-1:0] hold_data,
  input  logic [IDX_W-1:0]   hold_idx,
  input  logic               hold_intf,
  input  logic [LANES-1:0]   hold_lane,
  input  logic [7:0]         cal_len_m1,
  input  logic [LANE_W-1:0]  lane_cnt_m1,
  input  logic               status_en,
  output logic               ack_tgl,
  output logic               err_ref,
  output logic               frame_start_w,
  output logic               fc_clk_o,
  output logic               fc_data_o,
  output logic               fc_sync_o
);
  logic             req_s, take_w, ph, primed;
  logic [PAD_W-1:0] sh_cal;
  logic             sh_intf;
  logic [LANES-1:0] sh_lane, lane_mask;
  logic [PL_W-1:0]  pl_vec;
  logic [POS_W-1:0] pos, plen;
  logic [5:0]       segcnt;
  logic [1:0]       ccnt;
  logic [3:0]       crc;
  logic [8:0]       nact, tcount;
  ser_st_e          st;

  oobfc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(ref_clk), .rst_s(rst_s), .d(req_tgl), .q(req_s));

  assign take_w    = (req_s != ack_tgl);
  assign nact      = active_slices(cal_len_m1);
  assign plen      = POS_W'(payload_bits(cal_len_m1, 8'(lane_cnt_m1), status_en));
  assign lane_mask = LANES'((64'd1 << (int'(lane_cnt_m1) + 1)) - 64'd1);
  assign pl_vec    = status_en ?
                     ((PL_W'(sh_cal) << (int'(lane_cnt_m1) + 2)) |
                      PL_W'({sh_lane & lane_mask, sh_intf})) :
                     PL_W'(sh_cal);
  assign frame_start_w = ph && (st == ST_PAY) && (pos == '0) && primed;
  assign fc_clk_o  = ph;

  // slice capture and rate accounting
  always_ff @(posedge ref_clk or posedge rst_s) begin
    if (rst_s) begin
      ack_tgl <= 1'b0;
      sh_cal  <= '0;
      sh_intf <= 1'b0;
      sh_lane <= '0;
      tcount  <= '0;
      primed  <= 1'b0;
      err_ref <= 1'b0;
    end else begin
      if (take_w) begin
        ack_tgl <= req_s;
        sh_cal[int'(hold_idx)*SLICE_W +: SLICE_W] <= hold_data;
        if (hold_idx == '0) begin
          sh_intf <= hold_intf;
          sh_lane <= hold_lane;
        end
      end
      if (!primed && tcount >= nact) primed <= 1'b1;
      if (frame_start_w) begin
        if (tcount < nact) err_ref <= 1'b1;
        tcount <= take_w ? 9'd1 : 9'd0;
      end else if (take_w && tcount != '1) begin
        tcount <= tcount + 9'd1;
      end
    end
  end

  // bit engine: advances when the forwarded clock falls
  always_ff @(posedge ref_clk or posedge rst_s) begin
    if (rst_s) begin
      ph        <= 1'b0;
      st        <= ST_PAY;
      pos       <= '0;
      segcnt    <= '0;
      ccnt      <= '0;
      crc       <= 4'hF;
      fc_data_o <= 1'b0;
      fc_sync_o <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        case (st)
          ST_PAY: begin
            if (pos == '0 && !primed) begin
              fc_data_o <= 1'b0;
              fc_sync_o <= 1'b0;
            end else begin
              fc_data_o <= pl_vec[pos];
              fc_sync_o <= (pos == '0);
              crc       <= crc4_step(crc, pl_vec[pos]);
              pos       <= pos + 1'b1;
              segcnt    <= segcnt + 6'd1;
              if ((pos + 1'b1) == plen || segcnt == 6'd63) begin
                st   <= ST_CRC;
                ccnt <= '0;
              end
            end
          end
          ST_CRC: begin
            fc_data_o <= crc[3];
            fc_sync_o <= 1'b0;
            crc       <= {crc[2:0], 1'b0};
            ccnt      <= ccnt + 2'd1;
            if (ccnt == 2'd3) begin
              st     <= ST_PAY;
              crc    <= 4'hF;
              segcnt <= '0;
              if (pos == plen) pos <= '0;
            end
          end
          default: st <= ST_PAY;
        endcase
      end
    end
  end
endmodule

// File: rtl/oobfc_tx.sv
`timescale 1ns/1ps
module oobfc_tx
  import oobfc_pkg::*;
#(
  parameter int MAX_CALLEN  = 128,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NSEG   = (MAX_CALLEN + SLICE_W - 1) / SLICE_W,
  localparam int IDX_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  ref_clk,
  input  logic                  rst,
  input  logic [MAX_CALLEN-1:0] fc_vec,
  input  logic [7:0]            cal_len_m1,
  input  logic [LANE_W-1:0]     lane_cnt_m1,
  input  logic                  intf_ok,
  input  logic [LANES-1:0]      lane_ok,
  input  logic                  status_en,
  output logic [NSEG-1:0]       upd_stb,
  output logic                  rate_err,
  output logic                  fc_clk_o,
  output logic                  fc_data_o,
  output logic                  fc_sync_o
);
  logic               usr_rst_s, ref_rst_s;
  logic               req_tgl, ack_tgl, err_ref, frame_start_w;
  logic [SLICE_W-1:0] hold_data;
  logic [IDX_W-1:0]   hold_idx;
  logic               hold_intf;
  logic [LANES-1:0]   hold_lane;

  oobfc_rst_sync #(.STAGES(SYNC_STAGES)) u_usr_rst (
    .clk(clk), .rst_a(rst), .rst_s(usr_rst_s));
  oobfc_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_a(rst), .rst_s(ref_rst_s));

  oobfc_user_side #(.MAX_CALLEN(MAX_CALLEN), .LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_usr (
    .clk(clk), .rst_s(usr_rst_s), .fc_vec(fc_vec), .cal_len_m1(cal_len_m1),
    .intf_ok(intf_ok), .lane_ok(lane_ok), .ack_tgl(ack_tgl), .upd_stb(upd_stb),
    .req_tgl(req_tgl), .hold_data(hold_data), .hold_idx(hold_idx),
    .hold_intf(hold_intf), .hold_lane(hold_lane));

  oobfc_serial_side #(.MAX_CALLEN(MAX_CALLEN), .LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_ser (
    .ref_clk(ref_clk), .rst_s(ref_rst_s), .req_tgl(req_tgl), .hold_data(hold_data),
    .hold_idx(hold_idx), .hold_intf(hold_intf), .hold_lane(hold_lane),
    .cal_len_m1(cal_len_m1), .lane_cnt_m1(lane_cnt_m1), .status_en(status_en),
    .ack_tgl(ack_tgl), .err_ref(err_ref), .frame_start_w(frame_start_w),
    .fc_clk_o(fc_clk_o), .fc_data_o(fc_data_o), .fc_sync_o(fc_sync_o));

  oobfc_bit_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
    .clk(clk), .rst_s(usr_rst_s), .d(err_ref), .q(rate_err));
endmodule

// File: rtl/oobfc_tx_chk.sv
`timescale 1ns/1ps
module oobfc_tx_chk #(
  parameter int NSEG = 2
) (
  input logic            clk,
  input logic            ref_clk,
  input logic            rst,
  input logic            ref_rst_s,
  input logic [NSEG-1:0] upd_stb,
  input logic            rate_err,
  input logic            fc_clk_o,
  input logic            fc_data_o,
  input logic            fc_sync_o,
  input logic            frame_start_w
);
  // R8
  upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_stb));

  // R8
  upd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_stb != '0) |=> (upd_stb == '0));

  // R1
  fc_clk_toggle_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $past(!ref_rst_s) |-> (fc_clk_o != $past(fc_clk_o)));

  // R2
  data_edge_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!$stable(fc_data_o) || !$stable(fc_sync_o)) |-> $fell(fc_clk_o));

  // R5
  sync_start_chk: assert property (@(posedge ref_clk) disable iff (rst)
    frame_start_w |=> fc_sync_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rate_err |=> rate_err);
endmodule

bind oobfc_tx oobfc_tx_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .ref_clk(ref_clk), .rst(rst), .ref_rst_s(ref_rst_s),
  .upd_stb(upd_stb), .rate_err(rate_err), .fc_clk_o(fc_clk_o),
  .fc_data_o(fc_data_o), .fc_sync_o(fc_sync_o), .frame_start_w(frame_start_w));

// File: tb/sim_oobfc_tx.sv
`timescale 1ns/1ps
module sim_oobfc_tx;
  localparam int MAX_CALLEN = 128;
  localparam int LANES      = 4;
  localparam int NSEG       = 2;
  localparam int MAXF       = 160;
  localparam int NV         = 6;

  // {cal_len_m1[8], lane_cnt_m1[2], status_en, intf_ok, lane_ok[4], pattern[8]}
  localparam logic [23:0] VEC [NV] = '{
    {8'd127, 2'd3, 1'b1, 1'b1, 4'hF, 8'hA5},
    {8'd63,  2'd1, 1'b1, 1'b0, 4'h2, 8'h3C},
    {8'd64,  2'd0, 1'b0, 1'b1, 4'h5, 8'hF0},
    {8'd20,  2'd3, 1'b0, 1'b0, 4'h0, 8'h01},
    {8'd58,  2'd3, 1'b1, 1'b1, 4'h9, 8'h6B},
    {8'd127, 2'd2, 1'b0, 1'b1, 4'hF, 8'h96}
  };

  logic clk = 1'b0, ref_clk = 1'b0, rst = 1'b0, clk_run = 1'b1;
  logic [MAX_CALLEN-1:0] base_val = '0, alt_val = '0, fc_vec;
  logic [MAX_CALLEN-1:0] alt_a, alt_b;
  logic alt_mode = 1'b0;
  logic [7:0] cal_len_m1 = '0;
  logic [1:0] lane_cnt_m1 = '0;
  logic intf_ok = 1'b1, status_en = 1'b0;
  logic [LANES-1:0] lane_ok = '1;
  logic [NSEG-1:0] upd_stb;
  logic rate_err, fc_clk_o, fc_data_o, fc_sync_o;
  int n_chk = 0, n_fail = 0;
  int pc [NSEG];

  always #4 if (clk_run) clk = ~clk;   // 125 MHz user clock
  always #2.5 ref_clk = ~ref_clk;      // 200 MHz reference

  assign fc_vec = alt_mode ? alt_val : base_val;
  always @(negedge clk) alt_val <= upd_stb[0] ? alt_a : alt_b;
  always @(negedge clk) for (int i = 0; i < NSEG; i++) if (upd_stb[i]) pc[i]++;

  oobfc_tx #(.MAX_CALLEN(MAX_CALLEN), .LANES(LANES)) u0 (
    .clk(clk), .ref_clk(ref_clk), .rst(rst), .fc_vec(fc_vec), .cal_len_m1(cal_len_m1),
    .lane_cnt_m1(lane_cnt_m1), .intf_ok(intf_ok), .lane_ok(lane_ok), .status_en(status_en),
    .upd_stb(upd_stb), .rate_err(rate_err), .fc_clk_o(fc_clk_o),
    .fc_data_o(fc_data_o), .fc_sync_o(fc_sync_o));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MAXF-1:0] act, input logic [MAXF-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int build_frame(input logic [7:0] cl, input logic [1:0] lm,
      input bit sen, input bit intf, input logic [3:0] ln,
      input logic [MAX_CALLEN-1:0] fc, output logic [MAXF-1:0] f);
    logic [MAXF-1:0] p;
    int np, nf, inseg;
    logic [3:0] c;
    logic msb;
    p = '0; f = '0; np = 0; nf = 0; inseg = 0; c = 4'hF;
    if (sen) begin
      p[np] = intf; np++;
      for (int i = 0; i <= int'(lm); i++) begin p[np] = ln[i]; np++; end
    end
    for (int i = 0; i <= int'(cl); i++) begin p[np] = fc[i]; np++; end
    for (int i = 0; i < np; i++) begin
      f[nf] = p[i]; nf++;
      msb = c[3];
      c = {c[2:0], 1'b0};
      if (msb ^ p[i]) c = c ^ 4'h3;
      inseg++;
      if (inseg == 64 || i == np - 1) begin
        for (int k = 3; k >= 0; k--) begin f[nf] = c[k]; nf++; end
        c = 4'hF; inseg = 0;
      end
    end
    return nf;
  endfunction

  task automatic grab(input int total, output logic [MAXF-1:0] got,
                      output bit next_ok, output int stray);
    got = '0; stray = 0;
    do @(posedge fc_clk_o); while (fc_sync_o !== 1'b1);
    got[0] = fc_data_o;
    for (int i = 1; i < total; i++) begin
      @(posedge fc_clk_o);
      got[i] = fc_data_o;
      if (fc_sync_o) stray++;
    end
    @(posedge fc_clk_o);
    next_ok = (fc_sync_o === 1'b1);
  endtask

  task automatic do_reset(input logic [23:0] v);
    rst = 1'b1;
    cal_len_m1 = v[23:16]; lane_cnt_m1 = v[15:14]; status_en = v[13];
    intf_ok = v[12]; lane_ok = v[11:8];
    base_val = '0;
    for (int i = 0; i < MAX_CALLEN; i++)
      if (i <= int'(v[23:16])) base_val[i] = v[i % 8];
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [MAXF-1:0] exp_f, got_f;
    int total, stray;
    bit nxt;
    realtime t0, t1;
    rst = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v]);
      if (v == 0) begin
        #1;
        // R9 reset state
        check(fc_data_o == 0 && fc_sync_o == 0 && upd_stb == 0 && rate_err == 0,
              "R9", "idle outputs after reset",
              MAXF'({fc_data_o, fc_sync_o, upd_stb, rate_err}), '0);
      end
      total = build_frame(cal_len_m1, lane_cnt_m1, status_en, intf_ok, lane_ok, base_val, exp_f);
      grab(total, got_f, nxt, stray);
      for (int i = 0; i < NSEG; i++) pc[i] = 0;
      grab(total, got_f, nxt, stray);
      // R3 R4 content; R6 when status off, R7 when on
      check(got_f == exp_f, status_en ? "R3 R4 R7" : "R3 R4 R6", "frame bits", got_f, exp_f);
      // R5 one sync per frame, frames back to back
      check(nxt && stray == 0, "R5", "sync framing", MAXF'({nxt, stray}), MAXF'({1'b1, 32'd0}));
      // R8 round robin over active slices only
      begin
        bit ok8;
        ok8 = 1'b1;
        for (int i = 0; i < NSEG; i++)
          if ((i <= int'(cal_len_m1) / 64) ? (pc[i] == 0) : (pc[i] != 0)) ok8 = 1'b0;
        check(ok8, "R8", "strobe coverage", MAXF'({pc[1], pc[0]}), MAXF'(cal_len_m1 >> 6));
      end
      // R10 no error while user clock keeps up
      check(rate_err == 1'b0, "R10", "no rate error", MAXF'(rate_err), '0);
    end

    // R1 forwarded clock period is two reference periods
    @(posedge fc_clk_o); t0 = $realtime;
    @(posedge fc_clk_o); t1 = $realtime;
    check((t1 - t0) == 10.0, "R1", "fc_clk period", MAXF'(int'(t1 - t0)), MAXF'(10));

    // R8 latch timing: calendar differs outside the strobe cycle
    alt_a = '0; alt_b = '0;
    for (int i = 0; i < 64; i++) begin
      alt_a[i] = ((i * 7) % 5) < 2;
      alt_b[i] = ~alt_a[i];
    end
    alt_mode = 1'b1;
    do_reset({8'd63, 2'd0, 1'b0, 1'b1, 4'hF, 8'h00});
    total = build_frame(8'd63, 2'd0, 1'b0, 1'b1, 4'hF, alt_a, exp_f);
    grab(total, got_f, nxt, stray);
    grab(total, got_f, nxt, stray);
    check(got_f == exp_f, "R8", "slice latched in strobe cycle", got_f, exp_f);
    alt_mode = 1'b0;

    // R11 asynchronous reset clears outputs at once
    do_reset({8'd63, 2'd1, 1'b1, 1'b1, 4'hF, 8'h5A});
    grab(total, got_f, nxt, stray);
    repeat (20) @(posedge fc_clk_o);
    #1 rst = 1'b1;
    #1;
    check(fc_data_o == 0 && fc_sync_o == 0 && fc_clk_o == 0 && upd_stb == 0,
          "R11", "outputs under async reset",
          MAXF'({fc_data_o, fc_sync_o, fc_clk_o, upd_stb}), '0);

    // R10 stalled user clock raises a sticky error
    do_reset({8'd63, 2'd0, 1'b0, 1'b1, 4'hF, 8'hC3});
    total = build_frame(8'd63, 2'd0, 1'b0, 1'b1, 4'hF, base_val, exp_f);
    grab(total, got_f, nxt, stray);
    check(rate_err == 1'b0, "R10", "no error before stall", MAXF'(rate_err), '0);
    @(negedge clk);
    clk_run = 1'b0;
    #2000;
    clk_run = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    check(rate_err == 1'b1, "R10", "error after stall", MAXF'(rate_err), MAXF'(1));
    grab(total, got_f, nxt, stray);
    grab(total, got_f, nxt, stray);
    check(rate_err == 1'b1, "R10", "error stays set", MAXF'(rate_err), MAXF'(1));
    // R11 reset clears the flag
    rst = 1'b1;
    #1;
    check(rate_err == 1'b0, "R11", "error cleared by reset", MAXF'(rate_err), '0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule